// File: doc/BRIEF.md
# SPI Register Block-Write Target

This block is an SPI target that sits between a host controller and a 64 KiB byte-addressed register and buffer space. Each transaction lies between a fall and a rise of the active-low chip select. The first byte of a transaction is an opcode. A block-write opcode is followed by a two-byte start address, high byte first. Every later byte is then written to the local space through a single-cycle write port, and the address steps up by one after each byte. The number of data bytes is set only by when chip select rises.

A second opcode reads back the address pointer. After the opcode, the target shifts out the pointer's high and low bytes in turn. The host can use this to confirm where the next block write would have landed. All serial inputs are synchronised into the system clock. The SPI runs in mode 0 with the most significant bit first.

A frame that delivers at least one whole byte makes a busy flag rise when it ends. The flag stays high for a fixed hold time. The host must wait until busy is low before it starts a new transaction. A transaction that is started while busy is high is ignored completely.

Top module: `spi_regwr_target`

## Requirements
- R1: After reset, `busy`, `wr_en` and `spi_miso` are all low.
- R2: In a frame whose opcode byte is 0x0D, byte 1 gives address bits 15:8 and byte 2 gives bits 7:0. Each complete byte after that produces exactly one single-cycle `wr_en` pulse, with `wr_data` equal to that byte. Bytes are received in SPI mode 0, MSB first.
- R3: The first data byte of a write frame goes to the start address, and each following byte goes to the previous address plus one. The address wraps from 0xFFFF to 0x0000.
- R4: A rise of `spi_cs_n` ends the frame. A trailing partial byte of fewer than 8 bits is not written.
- R5: A write frame that ends before both address bytes are complete performs no write and leaves the address pointer unchanged.
- R6: A frame with an opcode other than 0x0D or 0x1E performs no write and leaves the pointer unchanged. The bytes that follow the opcode are discarded.
- R7: Opcode 0x1E returns, in the bytes after the opcode, the address pointer alternately as its high byte and its low byte. The sequence starts with the high byte, and each byte is shifted out MSB first on the falling edges of SCK. The pointer is the address the next write would use: the last written address plus one, or the loaded start address if no data byte followed it.
- R8: When `spi_cs_n` rises at the end of a frame that moved at least one complete byte, `busy` rises and stays high for exactly BUSY_CYCLES clocks. A frame with no complete byte leaves `busy` low.
- R9: A frame whose chip-select fall is seen while `busy` is high is ignored. It performs no write, does not change the pointer and does not raise `busy` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the host (mode 0) |
| spi_mosi | input | 1 | Serial data from the host |
| spi_cs_n | input | 1 | Active-low chip select that frames each transaction |
| spi_miso | output | 1 | Serial data to the host, registered |
| busy | output | 1 | High while the target cannot accept a new transaction |
| wr_en | output | 1 | Single-cycle write strobe to the local space |
| wr_addr | output | ADDR_W | Byte address of the current write |
| wr_data | output | 8 | Byte to be written |

## Verification
The hardest case to reach from the ports is a transaction that begins while the hold time of the previous one is still running. The correct outcome is silence: no write, no pointer change and no second busy pulse. To produce it, the stimulus drops chip select a few clocks after busy rises. It then sends a complete write frame and proves nothing changed by reading the pointer back. Aborted address phases and unknown opcodes are handled the same way: each is followed by a pointer readback, so that state the frame must not touch becomes visible at the ports.

// File: rtl/spi_regwr_pkg.sv
package spi_regwr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPCODE,
    PH_ADDR_HI,
    PH_ADDR_LO,
    PH_DATA,
    PH_READ,
    PH_DISCARD
  } phase_e;
endpackage

// File: rtl/spi_regwr_sync.sv
module spi_regwr_sync #(
  parameter int       W       = 3,
  parameter int       STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= RST_VAL;
    else     stage[0] <= d_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_chain
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= RST_VAL;
      else     stage[i] <= stage[i-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/spi_regwr_shift.sv
module spi_regwr_shift
  import spi_regwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi,
  input  logic              load_en,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              byte_done,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              miso
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr;

  always_ff @(posedge clk) begin
    if (rst) rx_byte <= '0;
    else if (sck_rise && bit_cnt == CNT_W'(BYTE_W-1))
      rx_byte <= {rx_sr[BYTE_W-2:0], mosi};
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      bit_cnt   <= '0;
      rx_sr     <= '0;
      tx_sr     <= '0;
      miso      <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (sck_rise) begin
        rx_sr <= {rx_sr[BYTE_W-2:0], mosi};
        if (bit_cnt == CNT_W'(BYTE_W-1)) begin
          bit_cnt   <= '0;
          byte_done <= 1'b1;
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
      if (load_en) begin
        tx_sr <= load_byte;
      end else if (sck_fall) begin
        miso  <= tx_sr[BYTE_W-1];
        tx_sr <= {tx_sr[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_regwr_hold.sv
module spi_regwr_hold #(
  parameter int CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(CYCLES + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (start) begin
      busy   <= 1'b1;
      remain <= CNT_W'(CYCLES - 1);
    end else if (busy) begin
      if (remain == '0) busy <= 1'b0;
      else              remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/spi_regwr_target.sv
module spi_regwr_target
  import spi_regwr_pkg::*;
#(
  parameter int          ADDR_W      = 16,
  parameter int          SYNC_STAGES = 2,
  parameter int          BUSY_CYCLES = 16,
  parameter logic [7:0]  OP_WRITE    = 8'h0D,
  parameter logic [7:0]  OP_PTR_READ = 8'h1E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  output logic              spi_miso,
  output logic              busy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data
);
  localparam int PTR_EXT_W = 2 * BYTE_W;

  logic [2:0] pins_s;
  logic       cs_s, sck_s, mosi_s;
  logic       cs_q, sck_q;
  logic       cs_fall, cs_rise, sck_rise, sck_fall;

  spi_regwr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .d_in ({spi_cs_n, spi_sck, spi_mosi}),
    .q    (pins_s)
  );

  assign cs_s   = pins_s[2];
  assign sck_s  = pins_s[1];
  assign mosi_s = pins_s[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q  <= 1'b1;
      sck_q <= 1'b0;
    end else begin
      cs_q  <= cs_s;
      sck_q <= sck_s;
    end
  end

  assign cs_fall  = cs_q & ~cs_s;
  assign cs_rise  = ~cs_q & cs_s;
  assign sck_rise = ~sck_q & sck_s & ~cs_s;
  assign sck_fall = sck_q & ~sck_s & ~cs_s;

  logic              byte_done;
  logic [BYTE_W-1:0] rx_byte;
  logic              load_en;
  logic [BYTE_W-1:0] load_byte;

  spi_regwr_shift u_shift (
    .clk       (clk),
    .rst       (rst),
    .clr       (cs_fall),
    .sck_rise  (sck_rise),
    .sck_fall  (sck_fall),
    .mosi      (mosi_s),
    .load_en   (load_en),
    .load_byte (load_byte),
    .byte_done (byte_done),
    .rx_byte   (rx_byte),
    .miso      (spi_miso)
  );

  phase_e             phase;
  logic [ADDR_W-1:0]  ptr_q;
  logic [BYTE_W-1:0]  addr_hi;
  logic               rd_lo;
  logic               got_byte;
  logic [PTR_EXT_W-1:0] ptr_ext;

  assign ptr_ext = PTR_EXT_W'(ptr_q);

  spi_regwr_hold #(.CYCLES(BUSY_CYCLES)) u_hold (
    .clk   (clk),
    .rst   (rst),
    .start (cs_rise & got_byte),
    .busy  (busy)
  );

  always_comb begin
    load_en   = 1'b0;
    load_byte = ptr_ext[PTR_EXT_W-1:BYTE_W];
    if (byte_done) begin
      if (phase == PH_OPCODE && rx_byte == OP_PTR_READ) begin
        load_en = 1'b1;
      end else if (phase == PH_READ) begin
        load_en   = 1'b1;
        load_byte = rd_lo ? ptr_ext[BYTE_W-1:0] : ptr_ext[PTR_EXT_W-1:BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      ptr_q    <= '0;
      addr_hi  <= '0;
      rd_lo    <= 1'b0;
      got_byte <= 1'b0;
      wr_en    <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (cs_fall) begin
        got_byte <= 1'b0;
        rd_lo    <= 1'b0;
        phase    <= busy ? PH_DISCARD : PH_OPCODE;
      end else if (cs_rise) begin
        phase <= PH_IDLE;
      end else if (byte_done) begin
        if (phase != PH_DISCARD && phase != PH_IDLE) got_byte <= 1'b1;
        case (phase)
          PH_OPCODE: begin
            if (rx_byte == OP_WRITE)         phase <= PH_ADDR_HI;
            else if (rx_byte == OP_PTR_READ) begin
              phase <= PH_READ;
              rd_lo <= 1'b1;
            end else                         phase <= PH_DISCARD;
          end
          PH_ADDR_HI: begin
            addr_hi <= rx_byte;
            phase   <= PH_ADDR_LO;
          end
          PH_ADDR_LO: begin
            ptr_q <= ADDR_W'({addr_hi, rx_byte});
            phase <= PH_DATA;
          end
          PH_DATA: begin
            wr_en   <= 1'b1;
            wr_addr <= ptr_q;
            wr_data <= rx_byte;
            ptr_q   <= ptr_q + 1'b1;
          end
          PH_READ:  rd_lo <= ~rd_lo;
          default:  phase <= phase;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_regwr_chk.sv
module spi_regwr_chk #(
  parameter int ADDR_W      = 16,
  parameter int BUSY_CYCLES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              cs_rise,
  input logic              cs_fall
);
  localparam int RUN_W = $clog2(BUSY_CYCLES + 2) + 1;

  logic [RUN_W-1:0]  run_len;
  logic [ADDR_W-1:0] prev_addr;
  logic              have_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_len   <= '0;
      prev_addr <= '0;
      have_prev <= 1'b0;
    end else begin
      run_len <= busy ? run_len + 1'b1 : '0;
      if (cs_fall)    have_prev <= 1'b0;
      else if (wr_en) have_prev <= 1'b1;
      if (wr_en) prev_addr <= wr_addr;
    end
  end

  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !wr_en);

  a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && have_prev) |-> (wr_addr == prev_addr + 1'b1));

  a_r8_busy_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cs_rise));

  a_r8_busy_width: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == RUN_W'(BUSY_CYCLES)));

  a_r9_no_write_busy: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !busy);
endmodule

bind spi_regwr_target spi_regwr_chk #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .busy    (busy),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .cs_rise (cs_rise),
  .cs_fall (cs_fall)
);

// File: tb/sim_spi_regwr_target.sv
module sim_spi_regwr_target;
  localparam int AW   = 16;
  localparam int BC   = 16;
  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic miso, busy, wr_en;
  logic [AW-1:0] wr_addr;
  logic [7:0] wr_data;

  always #4 clk = ~clk;

  spi_regwr_target #(.ADDR_W(AW), .BUSY_CYCLES(BC)) u0 (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_mosi(mosi), .spi_cs_n(cs_n),
    .spi_miso(miso), .busy(busy), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [23:0] expq[$];
  logic [15:0] model_ptr = 16'h0000;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && wr_en) begin
      if (expq.size() == 0) begin
        check(1'b0, "R2 unexpected write", int'({wr_addr, wr_data}), 0);
      end else begin
        logic [23:0] e;
        e = expq.pop_front();
        check({wr_addr, wr_data} == e, "R2/R3 write addr,data",
              int'({wr_addr, wr_data}), int'(e));
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = 8'h00;
    for (int b = 7; b > 7 - n; b--) begin
      mosi = tx[b];
      wait_clk(HALF);
      rx[b] = miso;
      sck = 1'b1;
      wait_clk(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic xbyte(input logic [7:0] tx);
    logic [7:0] r;
    xbits(tx, 8, r);
  endtask

  task automatic cs_begin();
    while (busy) @(negedge clk);
    cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic cs_end(output int width);
    wait_clk(HALF);
    cs_n  = 1'b1;
    width = 0;
    for (int k = 0; k < 8; k++) begin
      if (busy) break;
      @(negedge clk);
    end
    while (busy) begin
      width++;
      @(negedge clk);
    end
  endtask

  function automatic logic [7:0] data_of(input logic [15:0] s, input int i);
    return 8'(s * 3 + i * 29 + 8'h5B);
  endfunction

  task automatic do_write(input logic [15:0] start, input int len, input int tail);
    int w;
    logic [7:0] r;
    cs_begin();
    xbyte(8'h0D);
    xbyte(start[15:8]);
    xbyte(start[7:0]);
    for (int i = 0; i < len; i++) begin
      logic [15:0] a;
      a = start + 16'(i);
      expq.push_back({a, data_of(start, i)});
      xbyte(data_of(start, i));
    end
    if (tail > 0) xbits(8'hA5, tail, r);
    cs_end(w);
    check(expq.size() == 0, "R2/R4 all writes seen, no extra", expq.size(), 0);
    check(w == BC, "R8 busy width", w, BC);
    model_ptr = start + 16'(len);
    expq.delete();
  endtask

  task automatic read_ptr(input string req);
    int w;
    logic [7:0] r;
    cs_begin();
    xbits(8'h1E, 8, r);
    for (int k = 0; k < 4; k++) begin
      logic [7:0] e;
      e = (k % 2 == 0) ? model_ptr[15:8] : model_ptr[7:0];
      xbits(8'h00, 8, r);
      check(r == e, req, r, e);
    end
    cs_end(w);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int w;
    logic [7:0] r;
    logic [15:0] starts [4];
    starts[0] = 16'h0000; starts[1] = 16'h1234; starts[2] = 16'hABCD; starts[3] = 16'hFFFD;

    wait_clk(5);
    check(busy == 1'b0, "R1 busy after reset", busy, 0);
    check(wr_en == 1'b0, "R1 wr_en after reset", wr_en, 0);
    check(miso == 1'b0, "R1 miso after reset", miso, 0);
    rst = 1'b0;
    wait_clk(4);

    // R2 R3 R7: sweep start addresses and lengths, including wrap past 0xFFFF
    foreach (starts[s]) begin
      for (int len = 0; len <= 5; len++) begin
        do_write(starts[s], len, 0);
        read_ptr("R7 pointer readback after write");
      end
    end

    // R4: trailing partial bytes are dropped
    for (int t = 1; t <= 7; t += 3) begin
      do_write(16'h4400 + 16'(t), 2, t);
      read_ptr("R4 pointer after partial tail");
    end

    // R5: frames cut inside the address phase
    cs_begin(); xbyte(8'h0D); cs_end(w);
    read_ptr("R5 cut after opcode");
    cs_begin(); xbyte(8'h0D); xbyte(8'h77); cs_end(w);
    read_ptr("R5 cut after high address byte");
    cs_begin(); xbyte(8'h0D); xbyte(8'h77); xbits(8'h88, 3, r); cs_end(w);
    check(expq.size() == 0, "R5 no write", expq.size(), 0);
    read_ptr("R5 cut inside low address byte");

    // R6: unknown opcodes
    for (int i = 0; i < 16; i++) begin
      logic [7:0] op;
      op = 8'(i * 17 + 3);
      if (op == 8'h0D || op == 8'h1E) continue;
      cs_begin(); xbyte(op); xbyte(8'h12); xbyte(8'h34); xbyte(8'h56); cs_end(w);
      check(w == BC, "R6/R8 busy after unknown opcode", w, BC);
    end
    read_ptr("R6 pointer unchanged by unknown opcodes");

    // R8: frame with no complete byte
    cs_begin(); xbits(8'h0D, 5, r); cs_end(w);
    check(w == 0, "R8 no busy for empty frame", w, 0);

    // R9: frame begun while busy
    do_write(16'h2000, 1, 0);
    cs_begin();
    xbyte(8'h0D); xbyte(8'h20); xbyte(8'h10);
    wait_clk(HALF);
    cs_n = 1'b1;
    while (!busy) @(negedge clk);
    wait_clk(3);
    cs_n = 1'b0;
    wait_clk(HALF);
    xbyte(8'h0D); xbyte(8'h40); xbyte(8'h00); xbyte(8'h77);
    cs_end(w);
    check(w == 0, "R9 ignored frame raises no busy", w, 0);
    check(expq.size() == 0, "R9 no write", expq.size(), 0);
    model_ptr = 16'h2010;
    read_ptr("R9 pointer unchanged by ignored frame");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule